// File: doc/BRIEF.md
# Code-Context Cache Word Predictor

This block sits beside a data cache and predicts which words of a cache block will be referenced, so that a miss fetches only those words rather than the whole block. A small fully associative table is keyed by two things: a context made of the upper bits of the program counter of the instruction that missed, and the offset of the word inside the block that caused the miss. Each entry keeps the two most recent word-usage vectors seen for its key. A lookup returns their bitwise OR as the fetch mask. The requested word is always included in that mask.

When the cache evicts a line, it presents the line's stored context, its miss-initiator offset and the vector of words that were actually touched. That trains the table. If the key already has an entry, its histories shift by one. If not, a new entry is allocated. Allocation is steered by a two-state machine. In FILL, the lowest-numbered invalid entry receives the new key. The transition FILL to FULL is taken when the allocation that occupies the last invalid entry happens. In FULL, the state holds until reset, and a round-robin pointer picks the victim and then advances.

The table size and context width are parameters. The default is 16 entries with 6-bit contexts. Configurations of 32 entries with 4-bit contexts, and 16 entries with 8-bit contexts, are obtained by parameter override. Blocks are 4 words wide.

Top module: `cwp_predictor`

## Requirements
- R1: After reset the table holds no valid entry, `pred_valid` is low, and the first lookup reports `pred_none`=1 with mask 4'b1111.
- R2: A lookup hits only a valid entry whose context and miss offset both equal the lookup's. The same context with a different offset misses, and so does a different context with the same offset.
- R3: On a hit, the mask is the bitwise OR of the entry's two most recent usage vectors, plus the requested word.
- R4: Mask bit k stands for word k of the block. The bit selected by `lk_off` is always 1 in a returned mask, even when no stored history contains it.
- R5: A lookup that matches no entry returns mask 4'b1111 with `pred_none`=1. A hit returns `pred_none`=0.
- R6: Training on an existing key drops its older history, moves the newer history into the older slot, and stores the incoming vector as the newer one.
- R7: Training on a new key allocates an entry whose prediction is exactly the incoming vector plus the requested word. Entries are filled in ascending index order, starting at entry 0.
- R8: Once every entry is valid, each new key replaces the entry at a round-robin pointer. The pointer starts at entry 0, steps up by one per replacement and wraps at the last entry.
- R9: `pred_valid` rises in the cycle after `lk_valid` is sampled and is low in any cycle that follows a cycle without a lookup.
- R10: When a training and a lookup are presented in the same cycle, the lookup result already reflects that training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request for a miss |
| lk_ctx | input | CTX_W | Upper PC bits of the missing instruction |
| lk_off | input | OFF_W | Word offset that initiated the miss |
| tr_valid | input | 1 | Training request from an eviction |
| tr_ctx | input | CTX_W | Context stored with the evicted line |
| tr_off | input | OFF_W | Miss-initiator offset of the evicted line |
| tr_used | input | WORDS | Words referenced while the line was resident |
| pred_valid | output | 1 | Prediction result valid |
| pred_mask | output | WORDS | Words to fetch, bit k = word k |
| pred_none | output | 1 | No entry matched; whole block requested |

## Verification
The hardest case to reach is round-robin replacement. It happens only after every entry has been occupied by a distinct key, and the victim's identity is visible only as which key stops hitting. The stimulus first trains three keys, then fills the remaining thirteen slots with fresh contexts. It then trains two more new keys one after the other. After each one, it probes which old key was lost and which survived, and that reveals the pointer's start value and the direction it steps.

// File: rtl/cwp_pkg.sv
package cwp_pkg;

    // Occupancy state of the predictor table
    typedef enum logic [0:0] {
        FILL_S = 1'b0,   // at least one entry still invalid
        FULL_S = 1'b1    // all entries valid, replacement by round robin
    } fill_state_t;

endpackage

// File: rtl/cwp_match.sv
module cwp_match #(
    parameter int ENTRIES = 16,
    parameter int CTX_W   = 6,
    parameter int OFF_W   = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ENTRIES-1:0]               vld,
    input  logic [ENTRIES-1:0][CTX_W-1:0]    ctx,
    input  logic [ENTRIES-1:0][OFF_W-1:0]    off,
    input  logic [CTX_W-1:0]                 key_ctx,
    input  logic [OFF_W-1:0]                 key_off,
    output logic                             hit,
    output logic [IDX_W-1:0]                 hit_idx
);

    logic [ENTRIES-1:0] hit_vec;

    // Parallel compare: one comparator per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (ctx[g] == key_ctx) && (off[g] == key_off);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit = |hit_vec;

    // R2
    uniq_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/cwp_alloc.sv
module cwp_alloc #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] vld,
    input  logic               alloc_en,
    output logic [IDX_W-1:0]   victim
);
    import cwp_pkg::*;

    fill_state_t        state_q, state_d;
    logic [IDX_W-1:0]   rr_q;
    logic [IDX_W-1:0]   first_free;
    logic [ENTRIES-1:0] victim_oh;

    always_comb begin
        first_free = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) first_free = IDX_W'(i);
        end
    end

    // Output process: victim choice per state
    always_comb begin
        unique case (state_q)
            FILL_S: victim = first_free;
            FULL_S: victim = rr_q;
            default: victim = first_free;
        endcase
        victim_oh = '0;
        victim_oh[victim] = 1'b1;
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_S: if (alloc_en && ((vld | victim_oh) == '1)) state_d = FULL_S;
            FULL_S: state_d = FULL_S;
            default: state_d = FILL_S;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_S;
            rr_q    <= '0;
        end else begin
            state_q <= state_d;
            if (alloc_en && state_q == FULL_S) begin
                rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            end
        end
    end

    // R8
    full_all_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FULL_S) |-> (vld == '1));

    // R7
    fill_victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && state_q == FILL_S) |-> !vld[victim]);

    // R8
    rr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rr_q <= IDX_W'(ENTRIES - 1));

endmodule

// File: rtl/cwp_predictor.sv
module cwp_predictor #(
    parameter int ENTRIES = 16,
    parameter int CTX_W   = 6,
    parameter int WORDS   = 4,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [CTX_W-1:0] lk_ctx,
    input  logic [OFF_W-1:0] lk_off,
    input  logic             tr_valid,
    input  logic [CTX_W-1:0] tr_ctx,
    input  logic [OFF_W-1:0] tr_off,
    input  logic [WORDS-1:0] tr_used,
    output logic             pred_valid,
    output logic [WORDS-1:0] pred_mask,
    output logic             pred_none
);

    logic [ENTRIES-1:0]             vld_q, vld_d;
    logic [ENTRIES-1:0][CTX_W-1:0]  ctx_q, ctx_d;
    logic [ENTRIES-1:0][OFF_W-1:0]  off_q, off_d;
    logic [ENTRIES-1:0][WORDS-1:0]  hnew_q, hnew_d;
    logic [ENTRIES-1:0][WORDS-1:0]  hold_q, hold_d;

    logic             tr_hit, lk_hit;
    logic [IDX_W-1:0] tr_idx, lk_idx, victim;
    logic [WORDS-1:0] req_word, lk_mask;

    // Training compare against the current table
    cwp_match #(.ENTRIES(ENTRIES), .CTX_W(CTX_W), .OFF_W(OFF_W)) u_tr_match (
        .clk(clk), .rst_n(rst_n),
        .vld(vld_q), .ctx(ctx_q), .off(off_q),
        .key_ctx(tr_ctx), .key_off(tr_off),
        .hit(tr_hit), .hit_idx(tr_idx)
    );

    cwp_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk(clk), .rst_n(rst_n),
        .vld(vld_q), .alloc_en(tr_valid && !tr_hit),
        .victim(victim)
    );

    // Table update
    always_comb begin
        vld_d  = vld_q;
        ctx_d  = ctx_q;
        off_d  = off_q;
        hnew_d = hnew_q;
        hold_d = hold_q;
        if (tr_valid) begin
            if (tr_hit) begin
                hold_d[tr_idx] = hnew_q[tr_idx];
                hnew_d[tr_idx] = tr_used;
            end else begin
                vld_d[victim]  = 1'b1;
                ctx_d[victim]  = tr_ctx;
                off_d[victim]  = tr_off;
                hnew_d[victim] = tr_used;
                hold_d[victim] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            ctx_q  <= '0;
            off_q  <= '0;
            hnew_q <= '0;
            hold_q <= '0;
        end else begin
            vld_q  <= vld_d;
            ctx_q  <= ctx_d;
            off_q  <= off_d;
            hnew_q <= hnew_d;
            hold_q <= hold_d;
        end
    end

    // Lookup compare against the post-update table (training visible)
    cwp_match #(.ENTRIES(ENTRIES), .CTX_W(CTX_W), .OFF_W(OFF_W)) u_lk_match (
        .clk(clk), .rst_n(rst_n),
        .vld(vld_d), .ctx(ctx_d), .off(off_d),
        .key_ctx(lk_ctx), .key_off(lk_off),
        .hit(lk_hit), .hit_idx(lk_idx)
    );

    always_comb begin
        req_word = '0;
        req_word[lk_off] = 1'b1;
        lk_mask = lk_hit ? (hnew_d[lk_idx] | hold_d[lk_idx] | req_word) : '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid <= 1'b0;
            pred_mask  <= '1;
            pred_none  <= 1'b0;
        end else begin
            pred_valid <= lk_valid;
            if (lk_valid) begin
                pred_mask <= lk_mask;
                pred_none <= !lk_hit;
            end
        end
    end

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lk_valid) |-> pred_valid);

    // R4
    req_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> pred_mask[$past(lk_off)]);

    // R5
    none_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && pred_none) |-> (pred_mask == '1));

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> (vld_q == '0 && !pred_valid));

endmodule

// File: tb/cwp_predictor_test.sv
module cwp_predictor_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       lk_valid, tr_valid;
    logic [5:0] lk_ctx, tr_ctx;
    logic [1:0] lk_off, tr_off;
    logic [3:0] tr_used;
    logic       pred_valid, pred_none;
    logic [3:0] pred_mask;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    cwp_predictor uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ctx(lk_ctx), .lk_off(lk_off),
        .tr_valid(tr_valid), .tr_ctx(tr_ctx), .tr_off(tr_off), .tr_used(tr_used),
        .pred_valid(pred_valid), .pred_mask(pred_mask), .pred_none(pred_none)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic train(input logic [5:0] c, input logic [1:0] o, input logic [3:0] u);
        @(negedge clk);
        tr_valid = 1'b1; tr_ctx = c; tr_off = o; tr_used = u;
        @(negedge clk);
        tr_valid = 1'b0;
    endtask

    // Lookup and compare mask and no-prediction flag
    task automatic probe(input logic [5:0] c, input logic [1:0] o,
                         input logic [3:0] exp_mask, input bit exp_none, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_ctx = c; lk_off = o;
        @(negedge clk);
        lk_valid = 1'b0;
        check(pred_valid == 1'b1, req, pred_valid, 1);
        check(pred_mask == exp_mask, req, pred_mask, exp_mask);
        check(pred_none == exp_none, req, pred_none, exp_none);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(pred_valid == 1'b0, "R1", pred_valid, 0);
        probe(6'h05, 2'd0, 4'b1111, 1'b1, "R1");
    endtask

    task automatic t_key_match();
        train(6'h2A, 2'd1, 4'b0101);
        probe(6'h2A, 2'd1, 4'b0111, 1'b0, "R7");
        probe(6'h2A, 2'd2, 4'b1111, 1'b1, "R2");
        probe(6'h2B, 2'd1, 4'b1111, 1'b1, "R5");
    endtask

    task automatic t_history();
        train(6'h2A, 2'd1, 4'b0001);
        probe(6'h2A, 2'd1, 4'b0111, 1'b0, "R3");
        train(6'h2A, 2'd1, 4'b1000);
        probe(6'h2A, 2'd1, 4'b1011, 1'b0, "R3");
        train(6'h2A, 2'd1, 4'b0100);
        probe(6'h2A, 2'd1, 4'b1110, 1'b0, "R6");
    endtask

    task automatic t_force_word();
        train(6'h10, 2'd3, 4'b0001);
        probe(6'h10, 2'd3, 4'b1001, 1'b0, "R4");
    endtask

    task automatic t_latency();
        probe(6'h10, 2'd3, 4'b1001, 1'b0, "R9");
        @(negedge clk);
        check(pred_valid == 1'b0, "R9", pred_valid, 0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        tr_valid = 1'b1; tr_ctx = 6'h33; tr_off = 2'd0; tr_used = 4'b0110;
        lk_valid = 1'b1; lk_ctx = 6'h33; lk_off = 2'd0;
        @(negedge clk);
        tr_valid = 1'b0; lk_valid = 1'b0;
        check(pred_mask == 4'b0111, "R10", pred_mask, 4'b0111);
        check(pred_none == 1'b0, "R10", pred_none, 0);
    endtask

    task automatic t_replace();
        // Entries 0..2 hold 2A,10,33; fill 3..15
        for (int i = 0; i < 13; i++) train(6'(i), 2'd0, 4'b0010);
        probe(6'h0C, 2'd0, 4'b0011, 1'b0, "R7");
        train(6'h3E, 2'd0, 4'b0100);
        probe(6'h2A, 2'd1, 4'b1111, 1'b1, "R8");
        probe(6'h10, 2'd3, 4'b1001, 1'b0, "R8");
        train(6'h3F, 2'd0, 4'b0100);
        probe(6'h10, 2'd3, 4'b1111, 1'b1, "R8");
        probe(6'h33, 2'd0, 4'b0111, 1'b0, "R8");
        probe(6'h3E, 2'd0, 4'b0101, 1'b0, "R8");
    endtask

    initial begin
        rst_n = 1'b0; lk_valid = 1'b0; tr_valid = 1'b0;
        lk_ctx = '0; lk_off = '0; tr_ctx = '0; tr_off = '0; tr_used = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_key_match();
        t_history();
        t_force_word();
        t_latency();
        t_same_cycle();
        t_replace();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule